// File: doc/BRIEF.md
# Coprocessor Instruction Claim and Handshake Unit

This unit watches the instruction words a processor core drives onto a shared bus. It claims only the words addressed to the one hardware accelerator behind it. The core marks a bus word as a coprocessor instruction by pulling an active-low request strobe. The unit decodes that word and answers on two reply lines one cycle later. A pulse on the absent line means no accelerator here takes the word. The busy line held high means the core must stall and keep presenting the same word. Both lines low means the word was taken.

Each word that is taken becomes a 30-bit control vector and is pushed into a small first-in first-out command queue. The queue gives its oldest vector to the downstream sequencer, one per cycle, on any cycle in which the accelerator reports that it is idle. Moving data and sequencing the accelerator are handled by other blocks.

Top module: `cop_claim`

## Requirements
- R1: While reset is held and on the first cycle after it, `rep_absent`, `rep_busy` and `cmd_valid` are low.
- R2: A clock edge on which `cop_req_n` is high produces no reply and queues nothing, whatever the bus word is.
- R3: Word layout: class in bits [31:29], coded as 0, 1, 2, 3 and 4 for the five kinds. A requested word whose class field is 5, 6 or 7 raises `rep_absent` for exactly the next cycle. `rep_busy` stays low and nothing is queued.
- R4: Bits [28:25] are the accelerator index. A requested word whose index is not `UNIT_ID` is answered the same way as in R3.
- R5: Bits [24:21] are the operation number. A requested word whose operation bit in `OP_MASK` is 0 is answered the same way as in R3.
- R6: A valid requested word that finds a free queue slot is queued on that edge. In the next cycle both `rep_absent` and `rep_busy` are low.
- R7: A valid requested word that finds all `DEPTH` slots full, with no slot freed on that edge, drives `rep_busy` high in the next cycle and `rep_absent` low. The word is not queued.
- R8: A slot counts as free on the same edge on which the head entry leaves. A held, stalled word is therefore taken on that edge, and `rep_busy` drops.
- R9: On each edge where the queue holds at least one entry and `acc_busy` is low, the head entry leaves. `cmd_valid` is then high for the following cycle. An entry never leaves on an edge where `acc_busy` is high.
- R10: Entries leave in the order in which they were taken.
- R11: Vector layout: `cmd_vec[29:25]` is the class as one-hot, with bit 25 for class 0 up to bit 29 for class 4. `cmd_vec[24:0]` repeats word bits [24:0], which hold the operation, N [20:17], Rd [16:13], Rn [12:9] and offset [8:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cop_req_n | input | 1 | Low when the bus word is a coprocessor instruction |
| bus_word | input | 32 | Instruction word from the shared bus |
| acc_busy | input | 1 | High while the accelerator cannot take a command |
| rep_absent | output | 1 | One-cycle reply: no accelerator here claims the word |
| rep_busy | output | 1 | Stall reply: queue full, keep presenting the word |
| cmd_valid | output | 1 | `cmd_vec` carries a released command this cycle |
| cmd_vec | output | 30 | Decoded control vector of the released command |

## Verification
An error in the queue occupancy count first shows up on `rep_busy`. It either rises while a slot is still free or stays low after a fifth word has been taken. In both cases the bench sees it on the cycle after the offending strobe. Corrupted pointers show up at the next release, as a `cmd_vec` that arrives out of order or repeats. A wrong decode shows up as a reply of the wrong kind one cycle after the strobe. The bench runs a behavioural queue model alongside the design and compares every output on every clock, so each of these faults is caught in the first cycle in which it reaches a port.

// File: rtl/cop_pkg.sv
// Shared types for the coprocessor claim unit.
// Assumes a 32-bit instruction word with a 3-bit class in the top bits.
package cop_pkg;
    localparam int WORD_W = 32;
    localparam int CLS_N  = 5;
    localparam int CMD_W  = 30;

    typedef enum logic [2:0] {
        CLS_CDP = 3'd0,
        CLS_LDC = 3'd1,
        CLS_STC = 3'd2,
        CLS_MCR = 3'd3,
        CLS_MRC = 3'd4
    } cls_e;

    typedef struct packed {
        logic [CLS_N-1:0] cls_oh;
        logic [3:0]       op;
        logic [3:0]       cnt;
        logic [3:0]       rd;
        logic [3:0]       rn;
        logic [8:0]       offs;
    } cmd_t;
endpackage

// File: rtl/cop_decode.sv
// Combinational decoder: checks the class, the accelerator index and the
// operation number of a bus word, and builds the control vector.
// Assumes the word is stable for the whole cycle in which it is sampled.
module cop_decode
    import cop_pkg::*;
#(
    parameter logic [3:0]  UNIT_ID = 4'd5,
    parameter logic [15:0] OP_MASK = 16'h00FF
) (
    input  logic [WORD_W-1:0] word,
    output logic              hit,
    output cmd_t              cmd
);
    logic [2:0] cls_f;
    logic [3:0] idx_f;
    logic [3:0] op_f;
    logic       cls_ok;

    assign cls_f = word[31:29];
    assign idx_f = word[28:25];
    assign op_f  = word[24:21];

    // Class one-hot: one comparator per known class
    for (genvar c = 0; c < CLS_N; c++) begin : g_cls
        assign cmd.cls_oh[c] = (cls_f == 3'(c));
    end

    // Field extraction and the overall acceptance decision
    always_comb begin
        cls_ok   = |cmd.cls_oh;
        cmd.op   = op_f;
        cmd.cnt  = word[20:17];
        cmd.rd   = word[16:13];
        cmd.rn   = word[12:9];
        cmd.offs = word[8:0];
        hit      = cls_ok && (idx_f == UNIT_ID) && OP_MASK[op_f];
    end
endmodule

// File: rtl/cop_fifo.sv
// Command queue: DEPTH entries, single push and single pop per cycle.
// Assumes the caller never pushes into a full queue unless it pops on the same edge,
// and never pops an empty queue.
module cop_fifo #(
    parameter int W     = 30,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    // Storage write on push
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> (!full || pop)); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R10
endmodule

// File: rtl/cop_reply.sv
// Handshake replies to the core: registers the absent and busy answers
// and tells the top when a requested word is taken.
// Assumes the core keeps the word and the request in place while busy is high.
module cop_reply (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic hit,
    input  logic room,
    output logic take,
    output logic rep_absent,
    output logic rep_busy
);
    // A valid request is taken when a slot is free
    assign take = req && hit && room;

    // Reply registers, valid in the cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_absent <= 1'b0;
            rep_busy   <= 1'b0;
        end else begin
            rep_absent <= req && !hit;
            rep_busy   <= req && hit && !room;
        end
    end

    AST_REPLY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rep_absent && rep_busy)); // R3
    AST_ABSENT_MISS: assert property (@(posedge clk) disable iff (!rst_n) (req && !hit) |=> rep_absent); // R4
    AST_TAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) take |=> (!rep_busy && !rep_absent)); // R6
endmodule

// File: rtl/cop_claim.sv
// Top of the coprocessor claim unit: decode, handshake reply and command queue.
// Assumes a synchronous active-low reset and a single clock domain.
module cop_claim #(
    parameter logic [3:0]  UNIT_ID = 4'd5,
    parameter logic [15:0] OP_MASK = 16'h00FF,
    parameter int          DEPTH   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cop_req_n,
    input  logic [31:0]              bus_word,
    input  logic                     acc_busy,
    output logic                     rep_absent,
    output logic                     rep_busy,
    output logic                     cmd_valid,
    output logic [cop_pkg::CMD_W-1:0] cmd_vec
);
    import cop_pkg::*;

    cmd_t             dec_cmd;
    logic             dec_hit;
    logic             q_full, q_empty, q_pop, take, room;
    logic [CMD_W-1:0] q_head;

    cop_decode #(.UNIT_ID(UNIT_ID), .OP_MASK(OP_MASK)) u_dec (
        .word (bus_word),
        .hit  (dec_hit),
        .cmd  (dec_cmd)
    );

    // Release the head whenever something is stored and the accelerator is idle
    assign q_pop = !q_empty && !acc_busy;
    // A slot leaving on this edge counts as free
    assign room  = !q_full || q_pop;

    cop_reply u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (!cop_req_n),
        .hit        (dec_hit),
        .room       (room),
        .take       (take),
        .rep_absent (rep_absent),
        .rep_busy   (rep_busy)
    );

    cop_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .din   (dec_cmd),
        .pop   (q_pop),
        .dout  (q_head),
        .full  (q_full),
        .empty (q_empty)
    );

    // Output register toward the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_vec   <= '0;
        end else begin
            cmd_valid <= q_pop;
            if (q_pop) cmd_vec <= q_head;
        end
    end

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) acc_busy |=> !cmd_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cop_req_n |=> (!rep_absent && !rep_busy)); // R2
    AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> $onehot(cmd_vec[29:25])); // R11
endmodule

// File: tb/cop_claim_test.sv
`timescale 1ns/1ps
module cop_claim_test;
    localparam logic [3:0]  ID   = 4'd5;
    localparam logic [15:0] MASK = 16'h00FF;

    logic        clk = 1'b0, rst_n = 1'b0, req_n = 1'b1, acc_busy = 1'b1;
    logic [31:0] word = '0;
    logic        rep_absent, rep_busy, cmd_valid;
    logic [29:0] cmd_vec;

    cop_claim #(.UNIT_ID(ID), .OP_MASK(MASK), .DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .cop_req_n(req_n), .bus_word(word),
        .acc_busy(acc_busy), .rep_absent(rep_absent), .rep_busy(rep_busy),
        .cmd_valid(cmd_valid), .cmd_vec(cmd_vec)
    );

    always #4 clk = ~clk;

    int    checks = 0, errors = 0;
    string tag = "R1";
    bit    started = 1'b0, done = 1'b0;

    logic [29:0] q[$];
    bit          e_abs = 0, e_busy = 0, e_cv = 0;
    logic [29:0] e_vec = '0;

    function automatic logic [31:0] mk(int c, int i, int o, int n, int rd, int rn, int off);
        return {c[2:0], i[3:0], o[3:0], n[3:0], rd[3:0], rn[3:0], off[8:0]};
    endfunction

    function automatic logic [29:0] vec_of(logic [31:0] w);
        logic [4:0] oh;
        oh = 5'b00001 << w[31:29];
        return {oh, w[24:0]};
    endfunction

    function automatic bit ok(logic [31:0] w);
        return (w[31:29] < 3'd5) && (w[28:25] == ID) && MASK[w[24:21]];
    endfunction

    // Behavioural reference: a queue of vectors updated on each edge
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            q.delete();
            e_abs = 0; e_busy = 0; e_cv = 0;
        end else begin
            bit pop, v, was_full;
            was_full = (q.size() == 4);
            pop      = (q.size() > 0) && !acc_busy;
            v        = ok(word);
            e_abs    = !req_n && !v;
            e_busy   = !req_n && v && was_full && !pop;
            e_cv     = pop;
            if (pop) e_vec = q.pop_front();
            if (!req_n && v && (!was_full || pop)) q.push_back(vec_of(word));
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("rep_absent", 32'(rep_absent), 32'(e_abs));
            chk("rep_busy",   32'(rep_busy),   32'(e_busy));
            chk("cmd_valid",  32'(cmd_valid),  32'(e_cv));
            if (e_cv) chk("cmd_vec", 32'(cmd_vec), 32'(e_vec));
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: valid words without the strobe are ignored
        tag = "R2";
        acc_busy = 1'b0;
        for (int k = 0; k < 4; k++) begin
            word = mk(k, ID, k, 1, 2, 3, 100 + k);
            @(negedge clk);
        end

        // R6 and R11: each data class queued while busy, then released
        tag = "R6";
        acc_busy = 1'b1;
        for (int k = 1; k < 5; k++) begin
            req_n = 1'b0;
            word = mk(k, ID, 7 - k, k + 8, k, 15 - k, 300 + 37 * k);
            @(negedge clk);
        end
        req_n = 1'b1;
        tag = "R11";
        acc_busy = 1'b0;
        repeat (6) @(negedge clk);

        // R3: undefined classes
        tag = "R3";
        for (int k = 5; k < 8; k++) begin
            req_n = 1'b0; word = mk(k, ID, 1, 1, 1, 1, 1);
            @(negedge clk);
            req_n = 1'b1;
            @(negedge clk);
        end

        // R4: other accelerator indices
        tag = "R4";
        req_n = 1'b0; word = mk(0, 3, 2, 0, 0, 0, 0);
        @(negedge clk);
        word = mk(2, 15, 2, 4, 4, 4, 4);
        @(negedge clk);
        req_n = 1'b1;
        @(negedge clk);

        // R5: operation numbers outside the mask
        tag = "R5";
        req_n = 1'b0; word = mk(0, ID, 8, 0, 0, 0, 0);
        @(negedge clk);
        word = mk(3, ID, 15, 1, 2, 3, 511);
        @(negedge clk);
        req_n = 1'b1;
        @(negedge clk);

        // R10 then R7 and R8: fill, stall a fifth word, free a slot
        tag = "R10";
        acc_busy = 1'b1;
        for (int k = 0; k < 4; k++) begin
            req_n = 1'b0; word = mk(k, ID, k, k, k + 1, k + 2, 10 * k + 5);
            @(negedge clk);
        end
        tag = "R7";
        word = mk(0, ID, 6, 9, 9, 9, 499);
        repeat (3) @(negedge clk);
        tag = "R8";
        acc_busy = 1'b0;
        @(negedge clk);
        req_n = 1'b1;
        repeat (8) @(negedge clk);

        // R9: releases pause while the accelerator is busy
        tag = "R9";
        req_n = 1'b0; word = mk(1, ID, 3, 2, 1, 0, 7);
        acc_busy = 1'b1;
        @(negedge clk);
        word = mk(2, ID, 4, 3, 2, 1, 8);
        @(negedge clk);
        req_n = 1'b1;
        repeat (3) @(negedge clk);
        acc_busy = 1'b0;
        @(negedge clk);
        acc_busy = 1'b1;
        repeat (2) @(negedge clk);
        acc_busy = 1'b0;
        repeat (3) @(negedge clk);

        // R10: mixed traffic; the core holds its word while stalled
        tag = "R10";
        for (int k = 0; k < 400; k++) begin
            if (!rep_busy) begin
                logic [3:0] idx;
                idx   = ($urandom % 4 == 0) ? 4'($urandom) : ID;
                req_n = ($urandom % 3 == 0);
                word  = mk($urandom % 8, idx, $urandom % 10, $urandom, $urandom,
                           $urandom, $urandom);
            end
            acc_busy = ($urandom % 3 != 0);
            @(negedge clk);
        end
        req_n = 1'b1;
        acc_busy = 1'b0;
        repeat (8) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule